// File: doc/BRIEF.md
# Programmable Baud Clock Generator

This block is the bit-rate clock source for one channel of a dual-channel serial controller. A host loads a 16-bit divisor through two byte-wide register addresses, one for each half, and writes a control byte. That control byte starts or stops the generator, picks what it counts, and carries a clock-recovery command code. The counter runs on either every system clock or every synchronised rising edge of an external clock pin. When it reaches zero it reloads the divisor and flips a square-wave output.

The square wave can stand in for the channel's transmit bit clock, its receive bit clock, or both. When a direction is not routed to the generator, it uses its own pin clock. The command field in the control byte is decoded into a one-cycle strobe for a clock-recovery unit that lies outside this block. The command has no effect on counting. Three further control bits are held for read-back only.

Top module: `baud_clock_gen`

## Requirements
- R1: A synchronous active-high reset clears both divisor bytes, the control byte, the counter, the square-wave output and the command strobe to zero, and leaves the generator stopped. The output then stays low until the generator is started.
- R2: The divisor is {high byte, low byte}. The low byte is written and read at address 0, the high byte at address 1 and the control byte at address 2. Reading address 3 returns zero. Read data is combinational from `rd_addr`.
- R3: Control byte layout: bit 0 is the run enable. Bit 1 selects the count source: 1 for the system clock, 0 for the external pin.
- R4: A control write that changes the enable from 0 to 1 loads the counter with the divisor N. With the system-clock source, the output first rises N+1 cycles after the write edge and then toggles every N+1 cycles.
- R5: A control write that changes the enable from 1 to 0 stops the generator, clears the counter and forces the output low. The output then stays low.
- R6: The output toggles only when a count tick finds the counter at zero, and the counter then reloads from the divisor. A divisor written while the generator runs takes effect at the next reload. Writing the control byte again with the enable still 1 does not restart the count.
- R7: A divisor of zero makes the output toggle on every count tick.
- R8: With the pin source, the counter moves once per rising edge of `ext_clk`, after a two-stage synchroniser. The output toggles once every N+1 pin edges, and system clock cycles without pin edges do not advance it.
- R9: `tx_clk` equals the generator output when `tx_use_gen` is 1 and `tx_pin_clk` otherwise. `rx_clk` follows the same rule with `rx_use_gen` and `rx_pin_clk`.
- R10: Bits 7:5 of the control byte hold a command code k from 0 to 7. In the cycle after any control write, `cmd_strobe` has only bit k set, and it is zero otherwise. The code has no effect on the generator.
- R11: Control bits 4:2 are stored and read back unchanged, and they do not alter the output timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 low divisor, 1 high divisor, 2 control) |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Read data |
| ext_clk | input | 1 | External count clock pin |
| tx_pin_clk | input | 1 | Transmit clock from pin |
| rx_pin_clk | input | 1 | Receive clock from pin |
| tx_use_gen | input | 1 | Route generator output to transmit clock |
| rx_use_gen | input | 1 | Route generator output to receive clock |
| gen_clk | output | 1 | Generator square-wave output |
| tx_clk | output | 1 | Selected transmit bit clock |
| rx_clk | output | 1 | Selected receive bit clock |
| cmd_strobe | output | 8 | One-hot strobe of the decoded command code |

## Verification
The bench aims at the edges of the divide chain. A divisor of zero would stall an output that reloads only after a decrement. A divisor held only in the high byte would expose a swapped byte lane as a wildly wrong period. A divisor rewritten mid-count must not shorten the current half-period. A repeated enable write would reset the phase in a design that restarts on level instead of edge. A stop while the output is high would leave a stuck high level if the clear were missed. In pin mode, idle system cycles would produce toggles in a design that ignores the source select.

// File: rtl/brg_pkg.sv
package brg_pkg;

    localparam int TC_W         = 16;
    localparam int BYTE_W       = 8;
    localparam int NUM_TC_BYTES = TC_W / BYTE_W;
    localparam int ADDR_W       = 2;
    localparam int SYNC_STAGES  = 2;
    localparam int CMD_W        = 3;
    localparam int NUM_CMDS     = 1 << CMD_W;
    localparam int CLK_LANES    = 2;

    typedef logic [TC_W-1:0]   tc_t;
    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [CMD_W-1:0] {
        CMD_NOP           = 3'd0,
        CMD_SEARCH        = 3'd1,
        CMD_CLR_MISSING   = 3'd2,
        CMD_RECOVERY_OFF  = 3'd3,
        CMD_REC_FROM_GEN  = 3'd4,
        CMD_REC_FROM_PIN  = 3'd5,
        CMD_LINE_FM       = 3'd6,
        CMD_LINE_NRZI     = 3'd7
    } rec_cmd_e;

    // Control byte, MSB first: bit 0 is the run enable.
    typedef struct packed {
        rec_cmd_e cmd;
        logic     loopback;
        logic     echo;
        logic     req_fn;
        logic     src_sys;
        logic     enable;
    } ctrl_t;

    localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(NUM_TC_BYTES);

    function automatic logic [NUM_CMDS-1:0] cmd_onehot(rec_cmd_e c);
        return NUM_CMDS'(1) << c;
    endfunction

endpackage

// File: rtl/brg_regs.sv
module brg_regs
    import brg_pkg::*;
#(
    parameter int P_TC_W   = TC_W,
    parameter int P_BYTE_W = BYTE_W,
    parameter int P_ADDR_W = ADDR_W,
    parameter int P_CMDS   = NUM_CMDS
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [P_ADDR_W-1:0] wr_addr,
    input  logic [P_BYTE_W-1:0] wr_data,
    input  logic [P_ADDR_W-1:0] rd_addr,
    output logic [P_BYTE_W-1:0] rd_data,
    output logic [P_TC_W-1:0]   tc,
    output logic                run,
    output logic                src_sys,
    output logic                start_evt,
    output logic                stop_evt,
    output logic [P_CMDS-1:0]   cmd_strobe
);

    localparam int NB = P_TC_W / P_BYTE_W;

    logic [P_BYTE_W-1:0] tc_bytes [NB];
    ctrl_t ctrl_q;
    ctrl_t ctrl_new;
    logic  ctrl_wr;

    genvar b;
    generate
        for (b = 0; b < NB; b++) begin : g_tc_byte
            always_ff @(posedge clk) begin
                if (rst) begin
                    tc_bytes[b] <= '0;
                end else if (wr_en && wr_addr == P_ADDR_W'(b)) begin
                    tc_bytes[b] <= wr_data;
                end
            end
            assign tc[b*P_BYTE_W +: P_BYTE_W] = tc_bytes[b];
        end
    endgenerate

    assign ctrl_wr  = wr_en && (wr_addr == CTRL_ADDR);
    assign ctrl_new = ctrl_t'(wr_data);

    // Enable transitions are taken from the write itself.
    assign start_evt = ctrl_wr && ctrl_new.enable && !ctrl_q.enable;
    assign stop_evt  = ctrl_wr && !ctrl_new.enable && ctrl_q.enable;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q     <= '0;
            cmd_strobe <= '0;
        end else begin
            if (ctrl_wr) begin
                ctrl_q <= ctrl_new;
            end
            cmd_strobe <= ctrl_wr ? cmd_onehot(ctrl_new.cmd) : '0;
        end
    end

    assign run     = ctrl_q.enable;
    assign src_sys = ctrl_q.src_sys;

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NB; i++) begin
            if (rd_addr == P_ADDR_W'(i)) begin
                rd_data = tc_bytes[i];
            end
        end
        if (rd_addr == CTRL_ADDR) begin
            rd_data = ctrl_q;
        end
    end

endmodule

// File: rtl/brg_tick_src.sv
module brg_tick_src
    import brg_pkg::*;
#(
    parameter int P_SYNC = SYNC_STAGES
) (
    input  logic clk,
    input  logic rst,
    input  logic ext_clk,
    input  logic src_sys,
    output logic tick
);

    // P_SYNC synchroniser stages plus one history stage for edge detect.
    logic [P_SYNC:0] shift_q;
    logic            pin_rise;

    always_ff @(posedge clk) begin
        if (rst) begin
            shift_q <= '0;
        end else begin
            shift_q <= {shift_q[P_SYNC-1:0], ext_clk};
        end
    end

    assign pin_rise = shift_q[P_SYNC-1] & ~shift_q[P_SYNC];
    assign tick     = src_sys ? 1'b1 : pin_rise;

endmodule

// File: rtl/brg_counter.sv
module brg_counter
    import brg_pkg::*;
#(
    parameter int P_TC_W = TC_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              start_evt,
    input  logic              stop_evt,
    input  logic              tick,
    input  logic [P_TC_W-1:0] tc,
    output logic [P_TC_W-1:0] cnt,
    output logic              gen_clk
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            gen_clk <= 1'b0;
        end else if (stop_evt) begin
            cnt     <= '0;
            gen_clk <= 1'b0;
        end else if (start_evt) begin
            cnt <= tc;
        end else if (run && tick) begin
            if (cnt == '0) begin
                cnt     <= tc;
                gen_clk <= ~gen_clk;
            end else begin
                cnt <= cnt - P_TC_W'(1);
            end
        end
    end

endmodule

// File: rtl/brg_route.sv
module brg_route
    import brg_pkg::*;
#(
    parameter int P_LANES = CLK_LANES
) (
    input  logic               gen_clk,
    input  logic [P_LANES-1:0] pin_clk,
    input  logic [P_LANES-1:0] use_gen,
    output logic [P_LANES-1:0] lane_clk
);

    genvar l;
    generate
        for (l = 0; l < P_LANES; l++) begin : g_lane
            assign lane_clk[l] = use_gen[l] ? gen_clk : pin_clk[l];
        end
    endgenerate

endmodule

// File: rtl/baud_clock_gen.sv
module baud_clock_gen
    import brg_pkg::*;
#(
    parameter int P_TC_W   = TC_W,
    parameter int P_BYTE_W = BYTE_W,
    parameter int P_ADDR_W = ADDR_W,
    parameter int P_SYNC   = SYNC_STAGES,
    parameter int P_CMDS   = NUM_CMDS
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [P_ADDR_W-1:0] wr_addr,
    input  logic [P_BYTE_W-1:0] wr_data,
    input  logic [P_ADDR_W-1:0] rd_addr,
    output logic [P_BYTE_W-1:0] rd_data,
    input  logic                ext_clk,
    input  logic                tx_pin_clk,
    input  logic                rx_pin_clk,
    input  logic                tx_use_gen,
    input  logic                rx_use_gen,
    output logic                gen_clk,
    output logic                tx_clk,
    output logic                rx_clk,
    output logic [P_CMDS-1:0]   cmd_strobe
);

    logic [P_TC_W-1:0] tc_val;
    logic [P_TC_W-1:0] cnt_val;
    logic              run;
    logic              src_sys;
    logic              start_evt;
    logic              stop_evt;
    logic              tick;
    logic [1:0]        lanes;

    brg_regs #(
        .P_TC_W  (P_TC_W),
        .P_BYTE_W(P_BYTE_W),
        .P_ADDR_W(P_ADDR_W),
        .P_CMDS  (P_CMDS)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .tc        (tc_val),
        .run       (run),
        .src_sys   (src_sys),
        .start_evt (start_evt),
        .stop_evt  (stop_evt),
        .cmd_strobe(cmd_strobe)
    );

    brg_tick_src #(
        .P_SYNC(P_SYNC)
    ) u_tick (
        .clk    (clk),
        .rst    (rst),
        .ext_clk(ext_clk),
        .src_sys(src_sys),
        .tick   (tick)
    );

    brg_counter #(
        .P_TC_W(P_TC_W)
    ) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .start_evt(start_evt),
        .stop_evt (stop_evt),
        .tick     (tick),
        .tc       (tc_val),
        .cnt      (cnt_val),
        .gen_clk  (gen_clk)
    );

    brg_route #(
        .P_LANES(2)
    ) u_route (
        .gen_clk (gen_clk),
        .pin_clk ({rx_pin_clk, tx_pin_clk}),
        .use_gen ({rx_use_gen, tx_use_gen}),
        .lane_clk(lanes)
    );

    assign tx_clk = lanes[0];
    assign rx_clk = lanes[1];

endmodule

// File: rtl/brg_checker.sv
module brg_checker #(
    parameter int P_TC_W = 16,
    parameter int P_CMDS = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              start_evt,
    input logic              stop_evt,
    input logic              run,
    input logic              tick,
    input logic [P_TC_W-1:0] cnt,
    input logic [P_TC_W-1:0] tc,
    input logic              gen_clk,
    input logic              tx_use_gen,
    input logic              tx_clk,
    input logic              rx_use_gen,
    input logic              rx_clk,
    input logic [P_CMDS-1:0] cmd_strobe
);

    AST_START_LOADS: assert property (@(posedge clk) disable iff (rst)
        start_evt |=> cnt == $past(tc)); // R4

    AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (rst)
        stop_evt |=> (cnt == '0) && !gen_clk); // R5

    AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (!run && !start_evt && !stop_evt) |=> $stable(cnt) && $stable(gen_clk)); // R5

    AST_TERMINAL_TOGGLE: assert property (@(posedge clk) disable iff (rst)
        (run && !stop_evt && tick && cnt == '0) |=> (gen_clk != $past(gen_clk)) && (cnt == $past(tc))); // R6

    AST_NO_EARLY_TOGGLE: assert property (@(posedge clk) disable iff (rst)
        (run && !stop_evt && !(tick && cnt == '0)) |=> $stable(gen_clk)); // R6

    AST_TX_ROUTE: assert property (@(posedge clk) disable iff (rst)
        tx_use_gen |-> tx_clk == gen_clk); // R9

    AST_RX_ROUTE: assert property (@(posedge clk) disable iff (rst)
        rx_use_gen |-> rx_clk == gen_clk); // R9

    AST_CMD_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cmd_strobe)); // R10

endmodule

bind baud_clock_gen brg_checker #(
    .P_TC_W(P_TC_W),
    .P_CMDS(P_CMDS)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start_evt (start_evt),
    .stop_evt  (stop_evt),
    .run       (run),
    .tick      (tick),
    .cnt       (cnt_val),
    .tc        (tc_val),
    .gen_clk   (gen_clk),
    .tx_use_gen(tx_use_gen),
    .tx_clk    (tx_clk),
    .rx_use_gen(rx_use_gen),
    .rx_clk    (rx_clk),
    .cmd_strobe(cmd_strobe)
);

// File: tb/tb_baud_clock_gen.sv
module tb_baud_clock_gen;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;
    localparam logic [1:0] A_LO   = 2'd0;
    localparam logic [1:0] A_HI   = 2'd1;
    localparam logic [1:0] A_CTRL = 2'd2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       ext_clk = 1'b0;
    logic       tx_pin_clk = 1'b0;
    logic       rx_pin_clk = 1'b0;
    logic       tx_use_gen = 1'b0;
    logic       rx_use_gen = 1'b0;
    logic       gen_clk;
    logic       tx_clk;
    logic       rx_clk;
    logic [7:0] cmd_strobe;

    int  errors = 0;
    int  checks = 0;
    bit  done = 0;
    bit  tog_en = 0;
    int  toggles = 0;
    logic prev_gen = 1'b0;

    baud_clock_gen dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .ext_clk(ext_clk),
        .tx_pin_clk(tx_pin_clk), .rx_pin_clk(rx_pin_clk),
        .tx_use_gen(tx_use_gen), .rx_use_gen(rx_use_gen),
        .gen_clk(gen_clk), .tx_clk(tx_clk), .rx_clk(rx_clk), .cmd_strobe(cmd_strobe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        #2;
        if (tog_en && gen_clk !== prev_gen) toggles++;
        prev_gen = gen_clk;
    end

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete actual=hung expected=done");
            finish_run();
        end
    end

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int exp_level(int k, int f, int h);
        if (k < f) return 0;
        return (1 + (k - f) / h) % 2;
    endfunction

    task automatic wr(logic [1:0] a, logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(string req, logic [1:0] a, logic [7:0] exp);
        rd_addr = a;
        #1;
        chk(req, "read-back", rd_data, exp);
    endtask

    // Start the generator with system source and follow gen_clk cycle by cycle.
    task automatic run_sys(string req, int tc_first, int tc_later, logic [2:0] cmd,
                           logic [2:0] aux, int cycles, int mid_k,
                           logic [1:0] mid_a, logic [7:0] mid_d);
        logic [7:0] cv;
        int bad_k;
        int bad_act;
        int bad_exp;
        wr(A_CTRL, 8'h00);
        chk("R5", "level after stop", gen_clk, 0);
        wr(A_LO, tc_first[7:0]);
        wr(A_HI, tc_first[15:8]);
        cv = {cmd, aux, 1'b1, 1'b1};
        @(negedge clk);
        wr_en = 1'b1; wr_addr = A_CTRL; wr_data = cv;
        @(negedge clk);
        wr_en = 1'b0;
        chk("R10", "cmd strobe after write", cmd_strobe, 32'(8'(1) << cmd));
        bad_k = -1; bad_act = 0; bad_exp = 0;
        for (int k = 1; k <= cycles; k++) begin
            if (k == mid_k) begin
                wr_en = 1'b1; wr_addr = mid_a; wr_data = mid_d;
            end
            @(negedge clk);
            wr_en = 1'b0;
            if (k == 1 && mid_k != 1)
                chk("R10", "cmd strobe one cycle only", cmd_strobe, 0);
            if (bad_k < 0 && int'(gen_clk) != exp_level(k, tc_first + 1, tc_later + 1)) begin
                bad_k = k;
                bad_act = int'(gen_clk);
                bad_exp = exp_level(k, tc_first + 1, tc_later + 1);
            end
        end
        if (bad_k >= 0)
            $display("  first mismatch at cycle %0d after start (tc=%0d)", bad_k, tc_first);
        chk(req, "gen_clk waveform", bad_act, bad_exp);
        if (mid_k < 0 || mid_a != A_CTRL) rd_chk("R11", A_CTRL, cv);
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        @(negedge clk);
        rd_chk("R1", A_LO, 8'h00);
        rd_chk("R1", A_HI, 8'h00);
        rd_chk("R1", A_CTRL, 8'h00);
        chk("R1", "cmd strobe reset", cmd_strobe, 0);
        tog_en = 1; toggles = 0;
        repeat (20) @(negedge clk);
        tog_en = 0;
        chk("R1", "no toggles while stopped", toggles, 0);
        chk("R1", "gen_clk reset", gen_clk, 0);

        // R2: byte lanes and read map
        wr(A_LO, 8'hA5);
        wr(A_HI, 8'h3C);
        rd_chk("R2", A_LO, 8'hA5);
        rd_chk("R2", A_HI, 8'h3C);
        rd_chk("R2", 2'd3, 8'h00);

        // R4, R3: plain start, system source
        run_sys("R4", 4, 4, 3'd2, 3'd0, 40, -1, A_LO, 8'h00);
        // R7: zero divisor
        run_sys("R7", 0, 0, 3'd5, 3'd0, 12, -1, A_LO, 8'h00);
        // R2: divisor in the high byte
        run_sys("R2", 258, 258, 3'd1, 3'd0, 259 * 3, -1, A_LO, 8'h00);
        // R6: new divisor mid-count takes effect at reload
        run_sys("R6", 5, 1, 3'd0, 3'd0, 20, 2, A_LO, 8'h01);
        // R6: repeated enable write does not restart
        run_sys("R6", 3, 3, 3'd4, 3'd0, 20, 2, A_CTRL, 8'hE3);
        chk("R10", "strobe for rewrite", cmd_strobe, 0);
        // R11: aux bits have no timing effect
        run_sys("R11", 2, 2, 3'd6, 3'd7, 18, -1, A_LO, 8'h00);

        // R5: stop while output is high
        run_sys("R5", 1, 1, 3'd0, 3'd0, 2, -1, A_LO, 8'h00);
        chk("R5", "high before stop", gen_clk, 1);
        wr(A_CTRL, 8'h02);
        chk("R5", "low after stop", gen_clk, 0);
        tog_en = 1; toggles = 0;
        repeat (30) @(negedge clk);
        tog_en = 0;
        chk("R5", "held low after stop", toggles, 0);

        // R9: routing
        run_sys("R4", 0, 0, 3'd0, 3'd0, 1, -1, A_LO, 8'h00);
        tx_use_gen = 1'b0; rx_use_gen = 1'b1;
        tx_pin_clk = 1'b1; #1;
        chk("R9", "tx from pin high", tx_clk, 1);
        tx_pin_clk = 1'b0; #1;
        chk("R9", "tx from pin low", tx_clk, 0);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R9", "rx from generator", rx_clk, gen_clk);
        end
        tx_use_gen = 1'b1; rx_use_gen = 1'b0; rx_pin_clk = 1'b1;
        @(negedge clk);
        chk("R9", "tx from generator", tx_clk, gen_clk);
        chk("R9", "rx from pin", rx_clk, 1);

        // R8: external pin source, divisor 2
        wr(A_CTRL, 8'h00);
        wr(A_LO, 8'd2);
        wr(A_HI, 8'd0);
        ext_clk = 1'b0;
        wr(A_CTRL, 8'h01);
        rd_chk("R3", A_CTRL, 8'h01);
        tog_en = 1; toggles = 0;
        repeat (40) @(negedge clk);
        chk("R8", "system cycles ignored in pin mode", toggles, 0);
        for (int e = 0; e < 10; e++) begin
            @(negedge clk) ext_clk = 1'b1;
            repeat (4) @(negedge clk);
            ext_clk = 1'b0;
            repeat (3) @(negedge clk);
        end
        repeat (8) @(negedge clk);
        tog_en = 0;
        chk("R8", "toggles per pin edges", toggles, 10 / 3);

        // Random divisors, commands and aux bits with system source
        for (int it = 0; it < 10; it++) begin
            int t;
            logic [2:0] c;
            logic [2:0] x;
            t = $urandom_range(0, 12);
            c = 3'($urandom_range(0, 7));
            x = 3'($urandom_range(0, 7));
            if (it % 3 == 0)
                run_sys("R6", t, t, c, x, (t + 1) * 6, 1 + t / 2, A_CTRL, {c, x, 2'b11});
            else
                run_sys("R4", t, t, c, x, (t + 1) * 6, -1, A_LO, 8'h00);
        end

        done = 1;
        finish_run();
    end

endmodule